// File: doc/BRIEF.md
# Issue Stall and Interlock Calculator

This block prices one issue group of a dual-issue integer core. Each cycle in which a group is presented, it takes the descriptor of the group (a mandatory first slot and an optional second slot) plus the set of general registers written by the group issued in the previous cycle. From these it works out how many clock cycles the group occupies: the longer of the two slot latencies, then the extra cycles for each stall source.

It covers four stall sources. The first is an address-generation interlock, where a register written in the prior cycle is needed to form an address now; implicit stack-pointer use counts. The second is a data-cache bank clash between two paired memory accesses. The third is prefix-byte processing. The fourth is the sequencing penalty when two read-modify-write operations are paired. It does not decide whether the two instructions may pair, and it performs no memory access.

The result is registered. It appears with a one-cycle strobe on the clock edge after the group is presented, together with a flag for each stall source. The reset input is asserted asynchronously. Its release passes through a two-stage synchronizer inside the block.

Top module: `issue_stall_calc`

## Requirements
- R1: While `rst_n` is low, and until the second rising clock edge after it rises, `res_valid` is 0, `res_cycles` is 0 and all four stall flags are 0.
- R2: A group presented with `grp_valid` high at a rising edge produces `res_valid` high through the following cycle. A cycle with `grp_valid` low produces `res_valid` low in the following cycle, and `res_cycles` and the flags keep their previous values.
- R3: Slot class encoding: 0 = plain operation, 1 cycle; 1 = ALU with memory source, 2 cycles; 2 = ALU with memory source, 3-cycle form; 3 = read-modify-write with memory destination, 3 cycles. The base cost is the larger of the two slot costs. When `b_valid` is 0, none of the second slot's fields affect any output.
- R4: Register masks hold one bit per general register, with bit i standing for register i and bit 4 for the stack pointer. If `prev_wr` shares any bit with the address-register set of a valid slot, `res_agi` is 1 and one cycle is added.
- R5: A slot with its stack-use bit set adds bit 4 to its address-register set. It therefore stalls when `prev_wr[4]` is 1, and does not stall on stack use alone when `prev_wr[4]` is 0.
- R6: If both slots are valid, both access memory, and their bank fields (physical address bits 4 down to 2) are equal, `res_bank` is 1 and one cycle is added. Otherwise no cycle is added for banks.
- R7: The prefix counts of the valid slots are added to the total. `res_pfx` is 1 when that sum is nonzero.
- R8: If both slots are valid and both have class 3, `res_seq` is 1 and two cycles are added.
- R9: `res_cycles` equals the base cost plus the interlock, bank, prefix and sequencing terms, with all terms applied together in one group.
- R10: The interlock adds at most one cycle, however many registers overlap across the two slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | A group is presented this cycle |
| prev_wr | input | 8 | Registers written by the previous cycle's group (explicit destinations) |
| a_cls | input | 2 | First slot class (R3 encoding) |
| a_mem | input | 1 | First slot accesses data memory |
| a_bank | input | 3 | First slot physical address bits 4..2 |
| a_areg | input | 8 | First slot base/index register mask |
| a_stk | input | 1 | First slot uses the stack pointer implicitly |
| a_pfx | input | 2 | First slot prefix byte count |
| b_valid | input | 1 | Second slot is occupied |
| b_cls | input | 2 | Second slot class |
| b_mem | input | 1 | Second slot accesses data memory |
| b_bank | input | 3 | Second slot physical address bits 4..2 |
| b_areg | input | 8 | Second slot base/index register mask |
| b_stk | input | 1 | Second slot uses the stack pointer implicitly |
| b_pfx | input | 2 | Second slot prefix byte count |
| res_valid | output | 1 | Result strobe, one cycle |
| res_cycles | output | 5 | Total cycles for the group |
| res_agi | output | 1 | Address-generation interlock applied |
| res_bank | output | 1 | Bank clash applied |
| res_pfx | output | 1 | Prefix cycles applied |
| res_seq | output | 1 | Read-modify-write sequencing penalty applied |

## Verification
The bench drives a stack-use slot after a group that wrote the stack pointer, and again after one that did not. A design that ignored implicit stack use would miss the first stall, and one that treated any stack use as a hazard would add a cycle to the second. Bank fields that match, differ, or match with only one slot touching memory separate a correct bank test from one that ignores the memory flags. A second slot loaded with hazardous fields but marked empty exposes any logic that forgets `b_valid`. A group where two registers overlap at once, and a group with every stall source active together, catch an interlock that counts per register and sums that drop or double a term.

// File: rtl/isc_pkg.sv
package isc_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_LDALU2 = 2'd1,
    CLS_LDALU3 = 2'd2,
    CLS_RMW    = 2'd3
  } op_cls_e;

  localparam int unsigned NUM_SLOTS   = 2;
  localparam int unsigned SEQ_PENALTY = 2;

  function automatic logic [1:0] cls_latency(input op_cls_e c);
    logic [1:0] lat;
    case (c)
      CLS_PLAIN:  lat = 2'd1;
      CLS_LDALU2: lat = 2'd2;
      default:    lat = 2'd3;
    endcase
    return lat;
  endfunction

endpackage

// File: rtl/isc_slot_cost.sv
module isc_slot_cost
  import isc_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             slot_valid,
  input  logic [1:0]       slot_cls,
  output logic [CNT_W-1:0] slot_cycles,
  output logic             slot_rmw
);

  op_cls_e cls_e;

  always_comb begin
    cls_e       = op_cls_e'(slot_cls);
    slot_cycles = '0;
    slot_rmw    = 1'b0;
    if (slot_valid) begin
      slot_cycles = CNT_W'(cls_latency(cls_e));
      slot_rmw    = (cls_e == CLS_RMW);
    end
  end

endmodule

// File: rtl/isc_hazard.sv
module isc_hazard #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned SP_IDX = 4,
  parameter int unsigned BANK_W = 3
) (
  input  logic [NREG-1:0]   prev_wr,
  input  logic [NREG-1:0]   a_areg,
  input  logic              a_stk,
  input  logic              a_mem,
  input  logic [BANK_W-1:0] a_bank,
  input  logic              a_rmw,
  input  logic              b_valid,
  input  logic [NREG-1:0]   b_areg,
  input  logic              b_stk,
  input  logic              b_mem,
  input  logic [BANK_W-1:0] b_bank,
  input  logic              b_rmw,
  output logic              agi,
  output logic              bank,
  output logic              seq
);

  localparam logic [NREG-1:0] SP_BIT = NREG'(1) << SP_IDX;

  logic [NREG-1:0] use_a;
  logic [NREG-1:0] use_b;
  logic            pair_ok;

  always_comb begin
    pair_ok = b_valid;
    use_a   = a_areg | (a_stk ? SP_BIT : '0);
    use_b   = pair_ok ? (b_areg | (b_stk ? SP_BIT : '0)) : '0;
    // single interlock cycle regardless of overlap count
    agi     = |(prev_wr & (use_a | use_b));
    bank    = pair_ok && a_mem && b_mem && (a_bank == b_bank);
    seq     = pair_ok && a_rmw && b_rmw;
  end

endmodule

// File: rtl/isc_prefix_sum.sv
module isc_prefix_sum #(
  parameter int unsigned PREF_W = 2,
  parameter int unsigned CNT_W  = 5
) (
  input  logic [PREF_W-1:0] a_pfx,
  input  logic              b_valid,
  input  logic [PREF_W-1:0] b_pfx,
  output logic [CNT_W-1:0]  pfx_sum,
  output logic              pfx_any
);

  logic [PREF_W-1:0] b_eff;

  always_comb begin
    b_eff   = b_valid ? b_pfx : '0;
    pfx_sum = CNT_W'(a_pfx) + CNT_W'(b_eff);
    pfx_any = (pfx_sum != '0);
  end

endmodule

// File: rtl/issue_stall_calc.sv
module issue_stall_calc
  import isc_pkg::*;
#(
  parameter int unsigned NREG   = 8,
  parameter int unsigned SP_IDX = 4,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned PREF_W = 2,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_valid,
  input  logic [NREG-1:0]   prev_wr,
  input  logic [1:0]        a_cls,
  input  logic              a_mem,
  input  logic [BANK_W-1:0] a_bank,
  input  logic [NREG-1:0]   a_areg,
  input  logic              a_stk,
  input  logic [PREF_W-1:0] a_pfx,
  input  logic              b_valid,
  input  logic [1:0]        b_cls,
  input  logic              b_mem,
  input  logic [BANK_W-1:0] b_bank,
  input  logic [NREG-1:0]   b_areg,
  input  logic              b_stk,
  input  logic [PREF_W-1:0] b_pfx,
  output logic              res_valid,
  output logic [CNT_W-1:0]  res_cycles,
  output logic              res_agi,
  output logic              res_bank,
  output logic              res_pfx,
  output logic              res_seq
);

  localparam logic [CNT_W-1:0] SEQ_ADD = CNT_W'(SEQ_PENALTY);

  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // per-slot latency
  logic       sl_valid [NUM_SLOTS];
  logic [1:0] sl_cls   [NUM_SLOTS];
  logic [CNT_W-1:0] sl_cyc [NUM_SLOTS];
  logic       sl_rmw   [NUM_SLOTS];

  assign sl_valid[0] = 1'b1;
  assign sl_valid[1] = b_valid;
  assign sl_cls[0]   = a_cls;
  assign sl_cls[1]   = b_cls;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    isc_slot_cost #(.CNT_W(CNT_W)) u_cost (
      .slot_valid (sl_valid[g]),
      .slot_cls   (sl_cls[g]),
      .slot_cycles(sl_cyc[g]),
      .slot_rmw   (sl_rmw[g])
    );
  end

  logic hz_agi, hz_bank, hz_seq;

  isc_hazard #(.NREG(NREG), .SP_IDX(SP_IDX), .BANK_W(BANK_W)) u_hazard (
    .prev_wr(prev_wr),
    .a_areg (a_areg),
    .a_stk  (a_stk),
    .a_mem  (a_mem),
    .a_bank (a_bank),
    .a_rmw  (sl_rmw[0]),
    .b_valid(b_valid),
    .b_areg (b_areg),
    .b_stk  (b_stk),
    .b_mem  (b_mem),
    .b_bank (b_bank),
    .b_rmw  (sl_rmw[1]),
    .agi    (hz_agi),
    .bank   (hz_bank),
    .seq    (hz_seq)
  );

  logic [CNT_W-1:0] pfx_sum;
  logic             pfx_any;

  isc_prefix_sum #(.PREF_W(PREF_W), .CNT_W(CNT_W)) u_pfx (
    .a_pfx  (a_pfx),
    .b_valid(b_valid),
    .b_pfx  (b_pfx),
    .pfx_sum(pfx_sum),
    .pfx_any(pfx_any)
  );

  // next-state
  logic [CNT_W-1:0] base_cyc;
  logic [CNT_W-1:0] nxt_cycles;

  always_comb begin
    base_cyc   = (sl_cyc[1] > sl_cyc[0]) ? sl_cyc[1] : sl_cyc[0];
    nxt_cycles = base_cyc
               + CNT_W'(hz_agi)
               + CNT_W'(hz_bank)
               + pfx_sum
               + (hz_seq ? SEQ_ADD : '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid  <= 1'b0;
      res_cycles <= '0;
      res_agi    <= 1'b0;
      res_bank   <= 1'b0;
      res_pfx    <= 1'b0;
      res_seq    <= 1'b0;
    end else begin
      res_valid <= grp_valid;
      if (grp_valid) begin
        res_cycles <= nxt_cycles;
        res_agi    <= hz_agi;
        res_bank   <= hz_bank;
        res_pfx    <= pfx_any;
        res_seq    <= hz_seq;
      end
    end
  end

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    grp_valid |=> res_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !grp_valid |=> (!res_valid && $stable(res_cycles)));

  // R3
  floor_cost_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |-> (res_cycles >= CNT_W'(1)));

  // R4
  agi_cost_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && res_agi) |-> (res_cycles >= CNT_W'(2)));

  // R6
  bank_cost_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && res_bank) |-> (res_cycles >= CNT_W'(2)));

  // R7
  pfx_cost_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && res_pfx) |-> (res_cycles >= CNT_W'(2)));

  // R8
  seq_cost_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && res_seq) |-> (res_cycles >= CNT_W'(5)));

endmodule

// File: tb/issue_stall_calc_tb.sv
module issue_stall_calc_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       grp_valid;
  logic [7:0] prev_wr;
  logic [1:0] a_cls, b_cls;
  logic       a_mem, b_mem, a_stk, b_stk, b_valid;
  logic [2:0] a_bank, b_bank;
  logic [7:0] a_areg, b_areg;
  logic [1:0] a_pfx, b_pfx;
  logic       res_valid, res_agi, res_bank, res_pfx, res_seq;
  logic [4:0] res_cycles;

  issue_stall_calc u_dut (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .prev_wr(prev_wr),
    .a_cls(a_cls), .a_mem(a_mem), .a_bank(a_bank), .a_areg(a_areg),
    .a_stk(a_stk), .a_pfx(a_pfx),
    .b_valid(b_valid), .b_cls(b_cls), .b_mem(b_mem), .b_bank(b_bank),
    .b_areg(b_areg), .b_stk(b_stk), .b_pfx(b_pfx),
    .res_valid(res_valid), .res_cycles(res_cycles), .res_agi(res_agi),
    .res_bank(res_bank), .res_pfx(res_pfx), .res_seq(res_seq)
  );

  typedef struct {
    bit       bv;
    bit [1:0] ca, cb;
    bit       ma, mb, sa, sb;
    bit [2:0] ka, kb;
    bit [7:0] ra, rb, pw;
    bit [1:0] pa, pb;
  } grp_t;

  typedef struct {
    int    cyc;
    bit    agi, bank, pfx, seq;
    string tag;
  } exp_t;

  exp_t q[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;
  bit   have_last = 1'b0;
  logic [4:0] last_cyc;

  function automatic grp_t blank();
    grp_t g;
    g.bv = 0; g.ca = 0; g.cb = 0; g.ma = 0; g.mb = 0; g.sa = 0; g.sb = 0;
    g.ka = 0; g.kb = 0; g.ra = 0; g.rb = 0; g.pw = 0; g.pa = 0; g.pb = 0;
    return g;
  endfunction

  function automatic int lat(input bit [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 3;
  endfunction

  function automatic exp_t model(input grp_t g, input string tag);
    exp_t e;
    int   base, pf;
    bit [7:0] ua, ub;
    ua = g.ra | (g.sa ? 8'h10 : 8'h00);
    ub = g.bv ? (g.rb | (g.sb ? 8'h10 : 8'h00)) : 8'h00;
    base = lat(g.ca);
    if (g.bv && lat(g.cb) > base) base = lat(g.cb);
    pf = int'(g.pa) + (g.bv ? int'(g.pb) : 0);
    e.agi  = |(g.pw & (ua | ub));
    e.bank = g.bv && g.ma && g.mb && (g.ka == g.kb);
    e.seq  = g.bv && (g.ca == 2'd3) && (g.cb == 2'd3);
    e.pfx  = (pf != 0);
    e.cyc  = base + int'(e.agi) + int'(e.bank) + pf + (e.seq ? 2 : 0);
    e.tag  = tag;
    return e;
  endfunction

  task automatic send(input grp_t g, input string tag);
    @(negedge clk);
    grp_valid = 1'b1; prev_wr = g.pw; b_valid = g.bv;
    a_cls = g.ca; a_mem = g.ma; a_bank = g.ka; a_areg = g.ra; a_stk = g.sa; a_pfx = g.pa;
    b_cls = g.cb; b_mem = g.mb; b_bank = g.kb; b_areg = g.rb; b_stk = g.sb; b_pfx = g.pb;
    q.push_back(model(g, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      grp_valid = 1'b0;
      prev_wr = 8'hFF; a_cls = 2'd3; a_pfx = 2'd3;
    end
  endtask

  task automatic check_reset(input string when);
    tests++;
    if (res_valid !== 1'b0 || res_cycles !== 5'd0 ||
        {res_agi, res_bank, res_pfx, res_seq} !== 4'b0) begin
      fails++;
      $display("FAIL R1 %s: valid=%0b cycles=%0d flags=%b expected 0/0/0000",
               when, res_valid, res_cycles, {res_agi, res_bank, res_pfx, res_seq});
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_valid) begin
        exp_t e;
        tests++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected strobe: cycles=%0d expected no result", res_cycles);
        end else begin
          e = q.pop_front();
          if (int'(res_cycles) != e.cyc || res_agi != e.agi || res_bank != e.bank ||
              res_pfx != e.pfx || res_seq != e.seq) begin
            fails++;
            $display("FAIL %s: cycles=%0d agi/bank/pfx/seq=%b expected cycles=%0d flags=%b",
                     e.tag, res_cycles, {res_agi, res_bank, res_pfx, res_seq},
                     e.cyc, {e.agi, e.bank, e.pfx, e.seq});
          end
        end
        last_cyc  = res_cycles;
        have_last = 1'b1;
      end else if (have_last) begin
        tests++;
        if (res_cycles !== last_cyc) begin
          fails++;
          $display("FAIL R2 hold while idle: cycles=%0d expected %0d", res_cycles, last_cyc);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    grp_t g;
    rst_n = 1'b0; grp_valid = 1'b0; prev_wr = '0; b_valid = 0;
    a_cls = 0; a_mem = 0; a_bank = 0; a_areg = 0; a_stk = 0; a_pfx = 0;
    b_cls = 0; b_mem = 0; b_bank = 0; b_areg = 0; b_stk = 0; b_pfx = 0;
    repeat (3) @(negedge clk);
    check_reset("during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset("one edge after release");
    repeat (2) @(negedge clk);

    // R3 class latencies and max
    g = blank();                         send(g, "R3 plain single");
    g = blank(); g.ca = 1;               send(g, "R3 class1 single");
    g = blank(); g.bv = 1; g.cb = 2;     send(g, "R3 max of pair");
    g = blank(); g.bv = 0; g.cb = 3; g.pb = 3; g.rb = 8'hFF; g.sb = 1;
    g.ma = 1; g.mb = 1; g.pw = 8'hFF;    send(g, "R3 empty slot ignored");
    idle(2);
    // R4 interlock
    g = blank(); g.bv = 1; g.pw = 8'h08; g.rb = 8'h08; send(g, "R4 slot b base hit");
    g = blank(); g.pw = 8'h01; g.ra = 8'h02;           send(g, "R4 no overlap");
    // R10 single cycle for multiple overlaps
    g = blank(); g.bv = 1; g.pw = 8'h0C; g.ra = 8'h04; g.rb = 8'h08;
    send(g, "R10 two overlaps");
    // R5 implicit stack use
    g = blank(); g.sa = 1; g.pw = 8'h10; send(g, "R5 sp written then stack use");
    g = blank(); g.sa = 1; g.pw = 8'h08; send(g, "R5 stack use no sp write");
    idle(1);
    // R6 bank
    g = blank(); g.bv = 1; g.ma = 1; g.mb = 1; g.ka = 3; g.kb = 3; send(g, "R6 same bank");
    g = blank(); g.bv = 1; g.ma = 1; g.mb = 1; g.ka = 3; g.kb = 4; send(g, "R6 different bank");
    g = blank(); g.bv = 1; g.ma = 1; g.mb = 0; g.ka = 5; g.kb = 5; send(g, "R6 one memory access");
    // R7 prefixes
    g = blank(); g.pa = 1;                       send(g, "R7 one prefix");
    g = blank(); g.bv = 1; g.pa = 2; g.pb = 3;   send(g, "R7 prefix sum");
    // R8 sequencing
    g = blank(); g.bv = 1; g.ca = 3; g.cb = 3;   send(g, "R8 paired rmw");
    g = blank(); g.bv = 1; g.ca = 3; g.cb = 2;   send(g, "R8 rmw with non-rmw");
    idle(3);
    // R9 all terms together
    g = blank(); g.bv = 1; g.ca = 3; g.cb = 3; g.ma = 1; g.mb = 1; g.ka = 6; g.kb = 6;
    g.pa = 1; g.pw = 8'h10; g.sb = 1;            send(g, "R9 all sources");
    idle(3);

    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing results: pending=%0d expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule